// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block is a PC-style interval timer. It has three independent 16-bit down-counters behind a byte-wide I/O port interface. Software picks a channel through a control word written to the control port. The control word sets how the 16-bit count is moved across the 8-bit data port and which of six counting behaviours the channel follows. Software then loads a count through the channel's data port. A single-cycle count-enable input stands in for the slow timer input clock, about 1.19 MHz. On each pulse, every enabled channel whose gate is high counts down by one.

Channel 0's terminal-count events drive a one-cycle interrupt pulse. Channel 2's gate is driven from bit 0 of the system-control port, and the same port reads back that gate and channel 2's output. Channels 0 and 1 take their gates from input pins. A count can be frozen for reading in two ways: with a per-channel latch command, or with a read-back command that names several channels at once.

Each request is a single `io_valid` cycle, and every request is accepted in that cycle. The interface has no back-pressure, so the host must take each read response when it appears. A read request at the rising edge that ends cycle N produces `rd_valid` high, with `rd_data` stable, for the whole of cycle N+1.

Top module: `pit3_timer`

## Requirements
- R1: Address decode is on all 16 address bits. 0x0040, 0x0041 and 0x0042 are the data ports of channels 0, 1 and 2. 0x0043 is the control port, and a read there returns 0x00. 0x0061 is the system-control port. A read at any other address returns 0xFF, and a write there changes nothing. Every read gives `rd_valid` for exactly one cycle, in the cycle after the request.
- R2: Control word bit fields:
  - [7:6] is the channel; the value 3 means read-back.
  - [5:4] is the access: 0 latch, 1 low byte, 2 high byte, 3 low then high.
  - [3:1] is the counting mode.
  - Mode codes 6 and 7 behave as mode 0.
- R3: A non-latch control word stores the access and mode, returns both byte sequencers to the low byte and stops counting. The count then holds until a new count is loaded.
- R4: Loading in low-then-high access takes two writes. The first write sets the low byte of the reload value. The second write sets the high byte and starts the channel. Low-only access loads the byte itself. High-only access loads the byte times 256. Reads follow the same access: low then high, the low byte only, or the high byte only.
- R5: A loaded value of zero becomes a count of 0xFFFF.
- R6: After a load, the channel output is low in mode 0 and high in every other mode. All outputs are high after reset.
- R7: A latch command freezes the current count only when no latch is pending. A second latch while one is pending is ignored. In low-then-high access the pending latch is released by the high-byte read; in single-byte access it is released by one read. Later reads return the live count.
- R8: A read-back word with bit 5 clear latches every channel selected by bits 1, 2 and 3 (channels 0, 1 and 2). With bit 5 set, it latches nothing.
- R9: On a count-enable pulse, a channel that is started and has its gate high decrements its count by one. With the gate low, the count holds.
- R10: In modes 0, 1, 4 and 5, a pulse that finds the count at zero drives the output high, stops the channel and raises terminal count.
- R11: In mode 2, a pulse at zero reloads the count and raises terminal count, so a reload of N gives one event every N+1 pulses. In mode 3, a pulse at zero reloads the count and inverts the output, and terminal count is raised only when the output goes high.
- R12: Bit 0 of a write to 0x0061 sets channel 2's gate. A read of 0x0061 returns that gate in bit 0 and channel 2's output in bit 5, with all other bits 0. Channel 2's gate is low after reset.
- R13: `irq` is high for exactly the one cycle after a count-enable pulse that brought channel 0 to terminal count. Terminal counts on channels 1 and 2 never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | One-cycle I/O request, always accepted |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 8 | Read response byte |
| tick_en | input | 1 | Count-enable pulse (timer input clock) |
| ext_gate | input | 2 | Gates of channels 0 and 1 |
| tmr_out | output | 3 | Channel outputs |
| irq | output | 1 | Channel 0 terminal-count pulse |

## Verification
The bench issues a second latch while a first one is still pending. A design that overwrote the held value would return a count that has already moved on.

It reads back with the count bit set, then inspects the count in low-only access. A design that latched anyway would show a stale low byte.

It loads a zero count, and counts the pulses between interrupts in rate mode. A design that reloads one pulse early would show a shorter period.

It runs channel 2 in square-wave mode under the system-control gate, where the interrupt must stay quiet. It also runs the mode-6 fallback, where a design that took code 6 as a rate mode would leave its output high after the load.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_mode_e;

  localparam logic [2:0] MODE_ONESHOT_INT = 3'd0;
  localparam logic [2:0] MODE_RATE        = 3'd2;
  localparam logic [2:0] MODE_SQUARE      = 3'd3;
  localparam logic [2:0] MODE_LAST_VALID  = 3'd5;

  // zero means the full 16-bit range
  function automatic cnt_t widen_zero(cnt_t v);
    return (v == '0) ? '1 : v;
  endfunction

  // undefined codes fall back to the interrupt-on-terminal-count mode
  function automatic logic [2:0] legal_mode(logic [2:0] m);
    return (m > MODE_LAST_VALID) ? MODE_ONESHOT_INT : m;
  endfunction
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
  import pit_pkg::*;
#(
  parameter int          NCH       = 3,
  parameter int          AW        = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0040,
  parameter logic [15:0] SYS_ADDR  = 16'h0061
) (
  input  logic           io_valid,
  input  logic           io_write,
  input  logic [AW-1:0]  io_addr,
  input  byte_t          io_wdata,
  output logic [NCH-1:0] ch_prog,
  output logic [NCH-1:0] ch_latch,
  output logic [NCH-1:0] ch_wr,
  output logic [NCH-1:0] ch_rd,
  output acc_mode_e      cw_acc,
  output logic [2:0]     cw_mode,
  output logic           sys_wr,
  output logic           sys_rd,
  output logic           ctl_rd
);
  localparam logic [AW-1:0] CTL_ADDR = AW'(BASE_ADDR) + AW'(NCH);
  localparam logic [AW-1:0] SYS_A    = AW'(SYS_ADDR);

  logic       wr_req, rd_req, ctl_wr;
  logic [1:0] cw_sel;
  logic       cw_readback, cw_is_latch, rb_no_count;

  assign wr_req      = io_valid && io_write;
  assign rd_req      = io_valid && !io_write;
  assign ctl_wr      = wr_req && (io_addr == CTL_ADDR);
  assign ctl_rd      = rd_req && (io_addr == CTL_ADDR);
  assign sys_wr      = wr_req && (io_addr == SYS_A);
  assign sys_rd      = rd_req && (io_addr == SYS_A);
  assign cw_sel      = io_wdata[7:6];
  assign cw_readback = (cw_sel == 2'd3);
  assign cw_acc      = acc_mode_e'(io_wdata[5:4]);
  assign cw_mode     = io_wdata[3:1];
  assign cw_is_latch = (cw_acc == ACC_LATCH);
  assign rb_no_count = io_wdata[5];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] DATA_A = AW'(BASE_ADDR) + AW'(i);
    logic sel_hit;
    assign sel_hit     = !cw_readback && (cw_sel == 2'(i));
    assign ch_wr[i]    = wr_req && (io_addr == DATA_A);
    assign ch_rd[i]    = rd_req && (io_addr == DATA_A);
    assign ch_prog[i]  = ctl_wr && sel_hit && !cw_is_latch;
    assign ch_latch[i] = ctl_wr && ((sel_hit && cw_is_latch) ||
                                    (cw_readback && !rb_no_count && io_wdata[i+1]));
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_i,
  input  acc_mode_e  acc_i,
  input  logic [2:0] mode_i,
  input  logic       latch_i,
  input  logic       wr_i,
  input  byte_t      wdata_i,
  input  logic       rd_i,
  input  logic       tick_i,
  input  logic       gate_i,
  output byte_t      rdata_o,
  output logic       out_o,
  output logic       tc_o
);
  cnt_t       count_q, reload_q, hold_q;
  logic       hold_vld_q, rd_lo_q, wr_lo_q, run_q, out_q;
  acc_mode_e  acc_q;
  logic [2:0] mode_q;

  cnt_t  view, load_raw, load_val;
  logic  load_go, step, at_zero, stops_at_zero;

  // value seen by reads: frozen copy if held, else live count
  always_comb begin
    view = hold_vld_q ? hold_q : count_q;
    unique case (acc_q)
      ACC_HI:   rdata_o = view[15:8];
      ACC_LOHI: rdata_o = rd_lo_q ? view[7:0] : view[15:8];
      default:  rdata_o = view[7:0];
    endcase
  end

  always_comb begin
    load_go  = 1'b0;
    load_raw = '0;
    unique case (acc_q)
      ACC_LO:   begin load_go = wr_i;             load_raw = {8'h00, wdata_i}; end
      ACC_HI:   begin load_go = wr_i;             load_raw = {wdata_i, 8'h00}; end
      ACC_LOHI: begin load_go = wr_i && !wr_lo_q; load_raw = {wdata_i, reload_q[7:0]}; end
      default:  begin load_go = 1'b0;             load_raw = '0; end
    endcase
    load_val = widen_zero(load_raw);
  end

  assign step          = run_q && gate_i && tick_i;
  assign at_zero       = (count_q == '0);
  assign stops_at_zero = (mode_q != MODE_RATE) && (mode_q != MODE_SQUARE);
  assign tc_o          = step && at_zero && ((mode_q != MODE_SQUARE) || !out_q);
  assign out_o         = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q    <= '0;
      reload_q   <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      rd_lo_q    <= 1'b1;
      wr_lo_q    <= 1'b1;
      run_q      <= 1'b0;
      out_q      <= 1'b1;
      acc_q      <= ACC_LATCH;
      mode_q     <= MODE_ONESHOT_INT;
    end else begin
      // counting
      if (step) begin
        if (at_zero) begin
          if (stops_at_zero) begin
            out_q <= 1'b1;
            run_q <= 1'b0;
          end else begin
            count_q <= reload_q;
            if (mode_q == MODE_SQUARE) out_q <= !out_q;
          end
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
      // data read: byte sequencer and latch release
      if (rd_i) begin
        if (acc_q == ACC_LOHI) begin
          rd_lo_q <= !rd_lo_q;
          if (!rd_lo_q) hold_vld_q <= 1'b0;
        end else begin
          hold_vld_q <= 1'b0;
        end
      end
      // latch command
      if (latch_i && !hold_vld_q) begin
        hold_q     <= count_q;
        hold_vld_q <= 1'b1;
        rd_lo_q    <= 1'b1;
      end
      // data write
      if (wr_i && acc_q == ACC_LOHI) begin
        if (wr_lo_q) reload_q[7:0] <= wdata_i;
        wr_lo_q <= !wr_lo_q;
      end
      if (load_go) begin
        reload_q <= load_val;
        count_q  <= load_val;
        run_q    <= 1'b1;
        out_q    <= (mode_q != MODE_ONESHOT_INT);
      end
      // control word
      if (prog_i) begin
        acc_q   <= acc_i;
        mode_q  <= legal_mode(mode_i);
        rd_lo_q <= 1'b1;
        wr_lo_q <= 1'b1;
        run_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_rdmux.sv
module pit_rdmux
  import pit_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0]             ch_rd,
  input  logic [NCH-1:0][BYTE_W-1:0] ch_rdata,
  input  logic                       sys_rd,
  input  byte_t                      sys_byte,
  input  logic                       ctl_rd,
  output byte_t                      rd_byte
);
  logic [NCH:0][BYTE_W-1:0] acc_or;

  assign acc_or[0] = '0;
  for (genvar i = 0; i < NCH; i++) begin : g_or
    assign acc_or[i+1] = acc_or[i] | (ch_rd[i] ? ch_rdata[i] : '0);
  end

  always_comb begin
    if (|ch_rd)      rd_byte = acc_or[NCH];
    else if (sys_rd) rd_byte = sys_byte;
    else if (ctl_rd) rd_byte = 8'h00;
    else             rd_byte = 8'hFF;
  end
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer
  import pit_pkg::*;
#(
  parameter int          NCH       = 3,
  parameter int          AW        = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0040,
  parameter logic [15:0] SYS_ADDR  = 16'h0061
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_valid,
  input  logic           io_write,
  input  logic [AW-1:0]  io_addr,
  input  logic [7:0]     io_wdata,
  output logic           rd_valid,
  output logic [7:0]     rd_data,
  input  logic           tick_en,
  input  logic [NCH-2:0] ext_gate,
  output logic [NCH-1:0] tmr_out,
  output logic           irq
);
  localparam int SPK_CH = NCH - 1;

  logic [NCH-1:0]             ch_prog, ch_latch, ch_wr, ch_rd, ch_tc, ch_gate;
  logic [NCH-1:0][BYTE_W-1:0] ch_rdata;
  acc_mode_e                  cw_acc;
  logic [2:0]                 cw_mode;
  logic                       sys_wr, sys_rd, ctl_rd, spk_gate_q, irq_q, rvld_q;
  byte_t                      sys_byte, rd_byte, rdata_q;

  pit_bus_decode #(
    .NCH(NCH), .AW(AW), .BASE_ADDR(BASE_ADDR), .SYS_ADDR(SYS_ADDR)
  ) u_dec (
    .io_valid (io_valid),
    .io_write (io_write),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .ch_prog  (ch_prog),
    .ch_latch (ch_latch),
    .ch_wr    (ch_wr),
    .ch_rd    (ch_rd),
    .cw_acc   (cw_acc),
    .cw_mode  (cw_mode),
    .sys_wr   (sys_wr),
    .sys_rd   (sys_rd),
    .ctl_rd   (ctl_rd)
  );

  assign ch_gate = {spk_gate_q, ext_gate};

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    pit_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .prog_i  (ch_prog[i]),
      .acc_i   (cw_acc),
      .mode_i  (cw_mode),
      .latch_i (ch_latch[i]),
      .wr_i    (ch_wr[i]),
      .wdata_i (io_wdata),
      .rd_i    (ch_rd[i]),
      .tick_i  (tick_en),
      .gate_i  (ch_gate[i]),
      .rdata_o (ch_rdata[i]),
      .out_o   (tmr_out[i]),
      .tc_o    (ch_tc[i])
    );
  end

  assign sys_byte = {2'b00, tmr_out[SPK_CH], 4'b0000, spk_gate_q};

  pit_rdmux #(.NCH(NCH)) u_rdmux (
    .ch_rd    (ch_rd),
    .ch_rdata (ch_rdata),
    .sys_rd   (sys_rd),
    .sys_byte (sys_byte),
    .ctl_rd   (ctl_rd),
    .rd_byte  (rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spk_gate_q <= 1'b0;
      irq_q      <= 1'b0;
      rvld_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (sys_wr) spk_gate_q <= io_wdata[0];
      irq_q  <= ch_tc[0];
      rvld_q <= io_valid && !io_write;
      if (io_valid && !io_write) rdata_q <= rd_byte;
    end
  end

  assign irq      = irq_q;
  assign rd_valid = rvld_q;
  assign rd_data  = rdata_q;
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int          NCH      = 3,
  parameter logic [15:0] SYS_ADDR = 16'h0061
) (
  input logic           clk,
  input logic           rst_n,
  input logic           io_valid,
  input logic           io_write,
  input logic [15:0]    io_addr,
  input logic           tick_en,
  input logic [NCH-1:0] tmr_out,
  input logic           irq,
  input logic           rd_valid,
  input logic [7:0]     rd_data
);
  // R1: every read is answered in the following cycle
  p_read_answered_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write) |=> rd_valid);

  // R1: no response without a read request the cycle before
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(io_valid && !io_write));

  // R13: the interrupt only follows a count-enable pulse
  p_irq_needs_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick_en));

  // R10, R11: terminal count leaves channel 0's output high unless a write landed
  p_irq_out_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tmr_out[0] || $past(io_valid && io_write)));

  // R6: outputs move only on a count pulse or a bus write
  p_out_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !(io_valid && io_write)) |=> $stable(tmr_out));

  // R12: bit 5 of the system port reflects channel 2's output at request time
  p_sys_out_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && io_addr == SYS_ADDR) |=>
      (rd_data[5] == $past(tmr_out[NCH-1])));
endmodule

bind pit3_timer pit_checker #(.NCH(NCH), .SYS_ADDR(SYS_ADDR)) u_pit_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_valid (io_valid),
  .io_write (io_write),
  .io_addr  (io_addr),
  .tick_en  (tick_en),
  .tmr_out  (tmr_out),
  .irq      (irq),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/tb_pit3_timer.sv
module tb_pit3_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 34;
  // {op, req, addr, wdata, expected}; op 0 = write, 1 = read and compare, 2 = count pulse
  localparam logic [39:0] VEC [NV] = '{
    40'h0_2_0043_74_00, // R2 ch1, low-then-high, rate mode
    40'h0_4_0041_34_00, // R4 low byte
    40'h0_4_0041_12_00, // R4 high byte starts
    40'h1_4_0041_00_34,
    40'h1_4_0041_00_12,
    40'h2_9_0000_00_00, // R9 count 0x1233
    40'h0_7_0043_40_00, // R7 latch ch1
    40'h2_9_0000_00_00, // count 0x1232
    40'h0_7_0043_40_00, // R7 second latch ignored
    40'h1_7_0041_00_33,
    40'h1_7_0041_00_12,
    40'h1_7_0041_00_32, // released: live count
    40'h1_7_0041_00_12,
    40'h0_3_0043_50_00, // R3 low-only, mode 0
    40'h0_5_0041_00_00, // R5 zero load
    40'h1_5_0041_00_FF,
    40'h0_4_0043_60_00, // high-only
    40'h0_4_0041_02_00, // count 0x0200
    40'h1_4_0041_00_02,
    40'h0_8_0043_D4_00, // R8 read-back latch ch1
    40'h2_9_0000_00_00,
    40'h2_9_0000_00_00, // live 0x01FE
    40'h1_8_0041_00_02,
    40'h1_8_0041_00_01,
    40'h0_8_0043_F4_00, // R8 bit5 set: no latch
    40'h2_9_0000_00_00, // live 0x01FD
    40'h0_3_0043_50_00, // reprogram: stop
    40'h1_8_0041_00_FD,
    40'h2_3_0000_00_00, // stopped
    40'h1_3_0041_00_FD,
    40'h1_1_0050_00_FF, // R1 unclaimed
    40'h1_1_0043_00_00,
    40'h0_1_0141_99_00, // R1 upper address bits differ
    40'h1_1_0041_00_FD
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        tick_en = 1'b0;
  logic [1:0]  ext_gate = 2'b11;
  logic [2:0]  tmr_out;
  logic        irq;
  int          n_checks = 0, n_errs = 0, irq_seen;
  logic [7:0]  rb;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit3_timer dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_wdata(io_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .tick_en(tick_en), .ext_gate(ext_gate), .tmr_out(tmr_out), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_valid = 1; io_write = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_valid = 0; io_write = 0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_valid = 1; io_write = 0; io_addr = a;
    @(negedge clk); io_valid = 0;
    chk("R1 rd_valid", int'(rd_valid), 1);
    d = rd_data;
  endtask

  // one count pulse; on return irq shows that pulse's result
  task automatic pulse();
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R6, R12, R13)
    chk("R6 reset outputs", int'(tmr_out), 7);
    chk("R13 reset irq", int'(irq), 0);
    io_rd(16'h0061, rb); chk("R12 reset sys port", int'(rb), 8'h20);

    // vector table on channel 1
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op, rq;
      logic [15:0] a;
      logic [7:0]  d, e;
      {op, rq, a, d, e} = VEC[i];
      if (op == 4'd0) io_wr(a, d);
      else if (op == 4'd2) pulse();
      else begin
        io_rd(a, rb);
        chk($sformatf("R%0d vector %0d", rq, i), int'(rb), int'(e));
      end
    end

    // R6 R10 R13: mode 0 on channel 0, count 5
    io_wr(16'h0043, 8'h30); io_wr(16'h0040, 8'h05); io_wr(16'h0040, 8'h00);
    chk("R6 mode0 out low after load", int'(tmr_out[0]), 0);
    irq_seen = 0;
    for (int k = 0; k < 5; k++) begin pulse(); irq_seen += int'(irq); end
    chk("R10 no event before zero", irq_seen, 0);
    chk("R10 out still low", int'(tmr_out[0]), 0);
    pulse();
    chk("R13 irq on terminal pulse", int'(irq), 1);
    chk("R10 out high at terminal", int'(tmr_out[0]), 1);
    @(negedge clk);
    chk("R13 irq one cycle", int'(irq), 0);
    pulse();
    chk("R10 stopped after terminal", int'(irq), 0);

    // R11: rate mode, reload 3 -> event on pulses 4 and 8
    io_wr(16'h0043, 8'h34); io_wr(16'h0040, 8'h03); io_wr(16'h0040, 8'h00);
    chk("R6 rate out high after load", int'(tmr_out[0]), 1);
    irq_seen = 0;
    for (int k = 1; k <= 8; k++) begin
      pulse();
      if (irq) irq_seen++;
      chk($sformatf("R11 rate pulse %0d", k), int'(irq), (k % 4 == 0) ? 1 : 0);
    end
    chk("R11 rate event count", irq_seen, 2);

    // R2: mode code 6 acts as mode 0
    io_wr(16'h0043, 8'h1C); io_wr(16'h0040, 8'h02);
    chk("R2 mode6 out low", int'(tmr_out[0]), 0);
    pulse(); pulse(); pulse();
    chk("R2 mode6 terminal irq", int'(irq), 1);
    chk("R2 mode6 out high", int'(tmr_out[0]), 1);

    // R12 R9 R11: channel 2 square wave, reload 2
    io_wr(16'h0043, 8'hB6); io_wr(16'h0042, 8'h02); io_wr(16'h0042, 8'h00);
    pulse(); pulse(); pulse();
    io_rd(16'h0042, rb); chk("R9 ch2 gate low holds lo", int'(rb), 8'h02);
    io_rd(16'h0042, rb); chk("R9 ch2 gate low holds hi", int'(rb), 8'h00);
    io_wr(16'h0061, 8'h01);
    io_rd(16'h0061, rb); chk("R12 gate bit and out", int'(rb), 8'h21);
    irq_seen = 0;
    for (int k = 0; k < 3; k++) begin pulse(); irq_seen += int'(irq); end
    io_rd(16'h0061, rb); chk("R11 square toggles low", int'(rb), 8'h01);
    for (int k = 0; k < 3; k++) begin pulse(); irq_seen += int'(irq); end
    io_rd(16'h0061, rb); chk("R11 square toggles high", int'(rb), 8'h21);
    chk("R13 ch2 never raises irq", irq_seen, 0);

    // R9: external gate of channel 1
    io_wr(16'h0043, 8'h70); io_wr(16'h0041, 8'h10); io_wr(16'h0041, 8'h00);
    ext_gate = 2'b01;
    pulse(); pulse(); pulse();
    io_rd(16'h0041, rb); chk("R9 gate low holds", int'(rb), 8'h10);
    io_rd(16'h0041, rb);
    ext_gate = 2'b11;
    pulse();
    io_rd(16'h0041, rb); chk("R9 gate high counts", int'(rb), 8'h0F);
    io_rd(16'h0041, rb);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule